// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O Controller

This block gives a host processor three 8-bit parallel ports (A, B and C) behind a small memory-mapped window. The host selects the block with an active-low chip select and picks one of four locations with a two-bit address. It moves bytes with active-low read and write strobes. Each port has its own input pins, output latch and output-enable vector. Port C is handled as two 4-bit halves, and each half has its own direction.

The block treats a write to the control location in one of two ways, chosen by bit 7 of the written byte. If bit 7 is 1, the byte is a configuration word. It sets the port directions, stores the handshake-mode fields and clears every output latch. If bit 7 is 0, the byte is a single-bit command for port C. Every port behaves as simple unhandshaked I/O, whatever mode value is stored.

A small strobe state machine turns each write strobe into exactly one internal write, however long the host holds the strobe low. It has two states. `S_IDLE` waits for a strobe. The transition `S_IDLE -> S_HOLD` fires when chip select and write are both low, and the write is committed on that edge. `S_HOLD` waits for release. The transition `S_HOLD -> S_IDLE` fires as soon as chip select or write returns high. Reads are combinational and need no state.

Top module: `ppi_top`

## Requirements
- R1: After reset, all three output-enable vectors are 0x00, all output latches are 0x00, and a read of the control location (address 11) returns 0x9B.
- R2: Address 00 selects port A, 01 selects port B and 10 selects port C. A write to one of these loads that port's output latch with the data byte.
- R3: A control write with bit 7 = 1 sets the directions. Bit 4 = 1 makes port A an input, bit 3 = 1 makes C[7:4] an input, bit 1 = 1 makes port B an input and bit 0 = 1 makes C[3:0] an input. A port or half that is an output has all its enable bits at 1; an input has them at 0. Output enables change only through such a write.
- R4: A control write with bit 7 = 1 clears all three output latches to 0x00.
- R5: A control write with bit 7 = 0 sets port C latch bit number data[3:1] to data[0]. The other port C bits, the other latches, the directions and the stored configuration stay unchanged.
- R6: A read of a port or half configured as input returns its input pins. A read of one configured as output returns its output latch. Port C is decided per half.
- R7: A write strobe held low for several cycles performs exactly one write, using the data present on the first cycle.
- R8: A read of the control location returns {1, bits 6..0 of the last configuration word}. Mode bits 6..5 and 2 are stored, but they do not change port behaviour.
- R9: dout is 0x00 unless chip select and read are both low.
- R10: Write strobes while chip select is high change no latch and no enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| addr | input | 2 | Location select: 00 A, 01 B, 10 C, 11 control |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host |
| pa_in | input | 8 | Port A input pins |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B input pins |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C input pins |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables, one value per half |

## Verification
The checker tests these rules on every cycle:
- the output enables are off after reset;
- dout stays quiet outside reads;
- unselected strobes and held strobes leave the latches and enables alone;
- enables move only after a configuration write;
- a configuration write clears the latches;
- a single-bit command sets exactly the addressed port C bit and leaves the directions alone.

The bench scenarios cover the behaviour that depends on data:
- the read path, which picks pins or latch per port and per half;
- the readback of the stored mode bits;
- the reset value of the control location;
- the order of several single-bit commands.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
    localparam int PORT_W = 8;
    localparam int NIB_W  = PORT_W / 2;
    localparam int SEL_W  = $clog2(PORT_W);

    typedef enum logic [1:0] {
        ADR_A   = 2'b00,
        ADR_B   = 2'b01,
        ADR_C   = 2'b10,
        ADR_CTL = 2'b11
    } addr_e;

    // Field order matches control word bits 6..0
    typedef struct packed {
        logic [1:0] grp_a_mode;
        logic       a_is_in;
        logic       cu_is_in;
        logic       b_mode;
        logic       b_is_in;
        logic       cl_is_in;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{grp_a_mode: 2'b00, a_is_in: 1'b1, cu_is_in: 1'b1,
                                   b_mode: 1'b0, b_is_in: 1'b1, cl_is_in: 1'b1};

    typedef enum logic {S_IDLE, S_HOLD} strobe_st_e;
endpackage

// File: rtl/ppi_strobe_fsm.sv
module ppi_strobe_fsm
    import ppi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    output logic wr_fire
);
    strobe_st_e state, state_nx;
    logic       strobe;

    assign strobe = !cs_n && !wr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (strobe)  state_nx = S_HOLD;
            S_HOLD: if (!strobe) state_nx = S_IDLE;
            default:             state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        wr_fire = 1'b0;
        unique case (state)
            S_IDLE:  wr_fire = strobe;
            S_HOLD:  wr_fire = 1'b0;
            default: wr_fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/ppi_regs.sv
module ppi_regs
    import ppi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [1:0]        addr,
    input  logic [PORT_W-1:0] wdata,
    output cfg_t              cfg,
    output logic [PORT_W-1:0] pa_lat,
    output logic [PORT_W-1:0] pb_lat,
    output logic [PORT_W-1:0] pc_lat
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg    <= CFG_RESET;
            pa_lat <= '0;
            pb_lat <= '0;
            pc_lat <= '0;
        end else if (wr_fire) begin
            unique case (addr_e'(addr))
                ADR_A: pa_lat <= wdata;
                ADR_B: pb_lat <= wdata;
                ADR_C: pc_lat <= wdata;
                ADR_CTL: begin
                    if (wdata[PORT_W-1]) begin
                        cfg    <= cfg_t'(wdata[PORT_W-2:0]);
                        pa_lat <= '0;
                        pb_lat <= '0;
                        pc_lat <= '0;
                    end else begin
                        pc_lat[wdata[SEL_W:1]] <= wdata[0];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ppi_rdmux.sv
module ppi_rdmux
    import ppi_pkg::*;
(
    input  cfg_t              cfg,
    input  logic [1:0]        addr,
    input  logic              rd_active,
    input  logic [PORT_W-1:0] pa_lat,
    input  logic [PORT_W-1:0] pb_lat,
    input  logic [PORT_W-1:0] pc_lat,
    input  logic [PORT_W-1:0] pa_in,
    input  logic [PORT_W-1:0] pb_in,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] dout
);
    logic [PORT_W-1:0] pa_view, pb_view, pc_view;

    assign pa_view = cfg.a_is_in ? pa_in : pa_lat;
    assign pb_view = cfg.b_is_in ? pb_in : pb_lat;

    for (genvar g = 0; g < 2; g++) begin : g_half
        logic half_in;
        assign half_in = (g == 1) ? cfg.cu_is_in : cfg.cl_is_in;
        assign pc_view[g*NIB_W +: NIB_W] = half_in ? pc_in[g*NIB_W +: NIB_W]
                                                   : pc_lat[g*NIB_W +: NIB_W];
    end

    always_comb begin
        dout = '0;
        if (rd_active) begin
            unique case (addr_e'(addr))
                ADR_A:   dout = pa_view;
                ADR_B:   dout = pb_view;
                ADR_C:   dout = pc_view;
                ADR_CTL: dout = {1'b1, cfg};
                default: dout = '0;
            endcase
        end
    end
endmodule

// File: rtl/ppi_top.sv
module ppi_top
    import ppi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [1:0]        addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [PORT_W-1:0] din,
    output logic [PORT_W-1:0] dout,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic [PORT_W-1:0] pb_oe,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] pc_out,
    output logic [PORT_W-1:0] pc_oe
);
    logic wr_fire;
    cfg_t cfg;

    ppi_strobe_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .wr_fire(wr_fire)
    );

    ppi_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .addr(addr), .wdata(din),
        .cfg(cfg), .pa_lat(pa_out), .pb_lat(pb_out), .pc_lat(pc_out)
    );

    ppi_rdmux u_rdmux (
        .cfg(cfg), .addr(addr), .rd_active(!cs_n && !rd_n),
        .pa_lat(pa_out), .pb_lat(pb_out), .pc_lat(pc_out),
        .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in), .dout(dout)
    );

    assign pa_oe = {PORT_W{!cfg.a_is_in}};
    assign pb_oe = {PORT_W{!cfg.b_is_in}};
    assign pc_oe = {{NIB_W{!cfg.cu_is_in}}, {NIB_W{!cfg.cl_is_in}}};
endmodule

// File: rtl/ppi_top_chk.sv
module ppi_top_chk
    import ppi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic [1:0]        addr,
    input logic [PORT_W-1:0] din,
    input logic [PORT_W-1:0] dout,
    input logic              wr_fire,
    input logic [PORT_W-1:0] pa_out,
    input logic [PORT_W-1:0] pb_out,
    input logic [PORT_W-1:0] pc_out,
    input logic [PORT_W-1:0] pa_oe,
    input logic [PORT_W-1:0] pb_oe,
    input logic [PORT_W-1:0] pc_oe
);
    logic ctl_wr;
    assign ctl_wr = wr_fire && (addr == 2'b11);

    AST_RESET_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0)); // R1

    AST_OE_ONLY_BY_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({pa_oe, pb_oe, pc_oe}) |-> $past(ctl_wr && din[PORT_W-1])); // R3

    AST_CFG_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && din[PORT_W-1]) |=> (pa_out == '0 && pb_out == '0 && pc_out == '0)); // R4

    AST_BIT_CMD_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !din[PORT_W-1]) |=>
            (pc_out[$past(din[SEL_W:1])] == $past(din[0])) &&
            $stable({pa_oe, pb_oe, pc_oe, pa_out, pb_out})); // R5

    AST_HELD_STROBE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !cs_n && !wr_n && $past(!cs_n && !wr_n)) |=>
            $stable({pa_out, pb_out, pc_out, pa_oe, pb_oe, pc_oe})); // R7

    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (dout == '0)); // R9

    AST_UNSELECTED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable({pa_out, pb_out, pc_out, pa_oe, pb_oe, pc_oe})); // R10
endmodule

bind ppi_top ppi_top_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .wr_fire(wr_fire),
    .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
    .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe)
);

// File: tb/ppi_top_tb.sv
module ppi_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'b00;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic [7:0] pa_in = 8'hA5, pb_in = 8'h3C, pc_in = 8'h96;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    ppi_top u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
        .din(din), .dout(dout),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    // {is_write, addr, data, expected read}
    localparam int NV = 24;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 2'd3, 8'h00, 8'h9B}, {1'b0, 2'd0, 8'h00, 8'hA5},
        {1'b1, 2'd3, 8'h80, 8'h00}, {1'b0, 2'd3, 8'h00, 8'h80},
        {1'b1, 2'd0, 8'h12, 8'h00}, {1'b0, 2'd0, 8'h00, 8'h12},
        {1'b1, 2'd1, 8'h34, 8'h00}, {1'b0, 2'd1, 8'h00, 8'h34},
        {1'b1, 2'd2, 8'h56, 8'h00}, {1'b0, 2'd2, 8'h00, 8'h56},
        {1'b1, 2'd3, 8'h98, 8'h00}, {1'b0, 2'd0, 8'h00, 8'hA5},
        {1'b0, 2'd1, 8'h00, 8'h00}, {1'b0, 2'd2, 8'h00, 8'h90},
        {1'b1, 2'd3, 8'h07, 8'h00}, {1'b0, 2'd2, 8'h00, 8'h98},
        {1'b1, 2'd3, 8'h03, 8'h00}, {1'b0, 2'd2, 8'h00, 8'h9A},
        {1'b1, 2'd3, 8'h06, 8'h00}, {1'b0, 2'd2, 8'h00, 8'h92},
        {1'b0, 2'd3, 8'h00, 8'h98}, {1'b1, 2'd3, 8'hE4, 8'h00},
        {1'b0, 2'd3, 8'h00, 8'hE4}, {1'b0, 2'd0, 8'h00, 8'h00}
    };
    string vtag [NV] = '{
        "R1", "R6", "R3", "R8", "R2", "R2", "R2", "R2", "R2", "R2", "R3", "R6",
        "R4", "R6", "R5", "R5", "R5", "R5", "R5", "R5", "R5", "R3", "R8", "R4"
    };

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; addr = a; din = d; wr_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic do_read(input string tag, input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        cs_n = 1'b0; addr = a; rd_n = 1'b0;
        #2;
        check8(tag, dout, exp);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check8("R1_oe_a", pa_oe, 8'h00);
        check8("R1_oe_c", pc_oe, 8'h00);
        check8("R1_lat_c", pc_out, 8'h00);
        check8("R9_idle", dout, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][18]) do_write(VEC[i][17:16], VEC[i][15:8]);
            else            do_read(vtag[i], VEC[i][17:16], VEC[i][7:0]);
        end

        // R3 enables: A in, CU in, B out, CL out
        do_write(2'd3, 8'h98);
        @(negedge clk); #2;
        check8("R3_oe_a", pa_oe, 8'h00);
        check8("R3_oe_b", pb_oe, 8'hFF);
        check8("R3_oe_c", pc_oe, 8'h0F);
        do_write(2'd3, 8'hE4);
        @(negedge clk); #2;
        check8("R8_mode_no_effect_a", pa_oe, 8'hFF);
        check8("R8_mode_no_effect_c", pc_oe, 8'hFF);

        // R7 held strobe: only first data written
        @(negedge clk);
        cs_n = 1'b0; addr = 2'd0; din = 8'h11; wr_n = 1'b0;
        @(negedge clk); din = 8'h22;
        repeat (3) @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        #2;
        check8("R7_held", pa_out, 8'h11);

        // R10 unselected write ignored
        @(negedge clk);
        cs_n = 1'b1; addr = 2'd0; din = 8'h77; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        do_read("R10", 2'd0, 8'h11);

        // R9 selected but no read strobe
        @(negedge clk);
        cs_n = 1'b0; addr = 2'd3; rd_n = 1'b1;
        #2;
        check8("R9_no_rd", dout, 8'h00);
        cs_n = 1'b1;

        // R1 second reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #2;
        check8("R1_rereset_oe", pa_oe, 8'h00);
        check8("R1_rereset_lat", pa_out, 8'h00);
        rst_n = 1'b1;
        do_read("R1_rereset_ctl", 2'd3, 8'h9B);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule